// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Register Access

This block produces two independent pulse-width-modulated outputs, programmed through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A single shared control word holds one group of settings per channel. Each channel also has its own word that holds the waveform length and the active time. Each channel passes the module clock through a selectable divider and drives a period counter, and the counter value sets the output pin.

Software writes the period/duty word first and then sets the channel's gate and enable bits. A new period/duty value written while the channel runs is held until the current period ends, and a per-channel ready flag shows that a value is still waiting. Clearing the enable lets the running period finish before the pin goes to its resting level. A per-channel bypass bit sends the module clock straight to the pin and overrides all other settings.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: The control word is at address 0x0 and channel n's period/duty word is at 0x4+4*n. Channel n's control field starts at bit 15*n and holds: [3:0] divider code, bit 4 enable, bit 5 active level, bit 6 gate, bit 7 mode, bit 8 pulse, bit 9 bypass. All of these bits read back as written. The unused control bits read as 0 and cannot be written. The period/duty word reads back as written. Any other address reads as 0.
- R2: A channel runs only while both its gate bit and its enable bit are 1. Gate alone or enable alone leaves the pin at its resting level.
- R3: In the period/duty word, bits [31:16] hold P (the period length minus one) and bits [15:0] hold the duty D. The counter starts at 0 in the cycle after the channel starts and steps from 0 to P, once per divider tick. The output is active while the count is below D. A duty of 0 keeps the output inactive for the whole period.
- R4: Divider code 4'hF advances the counter every cycle. Codes 0 to 9 divide by DIV_UNIT times 2, 3, 4, 6, 8, 200, 400, 600, 800 and 1200. Codes 10 to 14 freeze the counter at its current value.
- R5: When the active-level bit is 1, the active level is high and the resting level is low. When the bit is 0, both levels are inverted.
- R6: A period/duty value written while the channel runs takes effect at the next period wrap. When the channel is idle, the value is taken one cycle after the write.
- R7: Control bit 28+n reads 1 from the cycle after a write to channel n's period/duty word until that value has been taken. It cannot be written.
- R8: When the enable or gate bit is cleared while the channel runs, the waveform continues to the end of the current period and then the pin goes to its resting level.
- R9: While bypass is set, the channel's pin follows the module clock, whatever the enable, gate, divider, period and polarity settings are. The running period is discarded.
- R10: After reset, all registers read 0 and every pin sits at the inverted resting level, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; it also feeds the divider and the bypass path |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_o | output | NCH | One waveform output per channel |

## Verification
The bench builds the block with NCH=2 and DIV_UNIT=1. With these values divider code 1 divides by 3, so a complete divided waveform spans only a few dozen cycles. A scoreboard predicts, sample by sample, when a queued period/duty value takes effect and how long a disabled channel keeps running. The bench also checks that a frozen divider code holds the pin steady, and that bypass passes both clock phases to the pin while the other channel is left alone.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;

    // Per-channel field layout inside the shared control word
    localparam int FIELD_STRIDE = 15;
    localparam int FIELD_W      = 10;
    localparam int RDY_BASE     = 28;
    localparam int B_EN         = 4;
    localparam int B_ACT        = 5;
    localparam int B_GATE       = 6;
    localparam int B_BYP        = 9;

    localparam logic [3:0] PSC_DIRECT = 4'hF;

    typedef struct packed {
        logic [3:0] psc;
        logic       en;
        logic       act;
        logic       gate;
        logic       byp;
    } chan_cfg_t;

    // Division ratio for a divider code; 0 means the counter is frozen
    function automatic int unsigned psc_ratio(input logic [3:0] code, input int unsigned unit);
        case (code)
            4'd0:       return 2 * unit;
            4'd1:       return 3 * unit;
            4'd2:       return 4 * unit;
            4'd3:       return 6 * unit;
            4'd4:       return 8 * unit;
            4'd5:       return 200 * unit;
            4'd6:       return 400 * unit;
            4'd7:       return 600 * unit;
            4'd8:       return 800 * unit;
            4'd9:       return 1200 * unit;
            PSC_DIRECT: return 1;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_ctrl_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [31:0]           wdata,
    input  logic [NCH-1:0]        ready,
    output logic [31:0]           rdata,
    output chan_cfg_t [NCH-1:0]   cfg,
    output logic [NCH-1:0][31:0]  pd,
    output logic [NCH-1:0]        pd_wr
);

    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m[n*FIELD_STRIDE +: FIELD_W] = '1;
        end
        return m;
    endfunction

    localparam logic [31:0] CTRL_MASK = ctrl_mask();

    typedef struct packed {
        logic [31:0]          ctrl;
        logic [NCH-1:0][31:0] pd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pd_wr = '0;
        if (we && addr == '0) begin
            st_d.ctrl = wdata & CTRL_MASK;
        end
        for (int n = 0; n < NCH; n++) begin
            if (we && addr == AW'(4 * (n + 1))) begin
                st_d.pd[n] = wdata;
                pd_wr[n]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0) begin
            rdata = st_q.ctrl;
            for (int n = 0; n < NCH; n++) begin
                rdata[RDY_BASE + n] = ready[n];
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (addr == AW'(4 * (n + 1))) begin
                rdata = st_q.pd[n];
            end
        end
    end

    assign pd = st_q.pd;

    for (genvar g = 0; g < NCH; g++) begin : g_cfg
        localparam int BASE = g * FIELD_STRIDE;
        assign cfg[g].psc  = st_q.ctrl[BASE +: 4];
        assign cfg[g].en   = st_q.ctrl[BASE + B_EN];
        assign cfg[g].act  = st_q.ctrl[BASE + B_ACT];
        assign cfg[g].gate = st_q.ctrl[BASE + B_GATE];
        assign cfg[g].byp  = st_q.ctrl[BASE + B_BYP];
    end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_ctrl_pkg::*;
#(
    parameter int unsigned DIV_UNIT = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);

    localparam int unsigned MAX_RATIO = 1200 * DIV_UNIT;
    localparam int          CW        = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } psc_t;

    psc_t st_d, st_q;
    logic [CW:0] ratio;
    logic [CW:0] cnt_inc;

    always_comb begin
        ratio   = (CW + 1)'(psc_ratio(code, DIV_UNIT));
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        tick    = run && (ratio != '0) && (cnt_inc >= ratio);
        st_d    = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else if (ratio != '0) begin
            st_d.cnt = cnt_inc[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        req,
    input  logic        byp,
    input  logic        act,
    input  logic        pd_wr,
    input  logic [31:0] pd,
    output logic        wave,
    output logic        ready,
    output logic        running,
    output logic        wrap
);

    typedef struct packed {
        logic        running;
        logic [15:0] cnt;
        logic [15:0] prd;
        logic [15:0] duty;
        logic        pend;
    } chan_t;

    chan_t st_d, st_q;
    logic  load;
    logic  active;

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        wrap = st_q.running && tick && (st_q.cnt >= st_q.prd);
        if (byp) begin
            st_d.running = 1'b0;
            st_d.cnt     = '0;
        end else if (!st_q.running) begin
            load = st_q.pend;
            if (req) begin
                st_d.running = 1'b1;
                st_d.cnt     = '0;
            end
        end else if (tick) begin
            if (wrap) begin
                st_d.cnt = '0;
                load     = st_q.pend;
                if (!req) begin
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 16'd1;
            end
        end
        if (load) begin
            st_d.prd  = pd[31:16];
            st_d.duty = pd[15:0];
            st_d.pend = 1'b0;
        end
        if (pd_wr) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.running && (st_q.cnt < st_q.duty);
    assign wave    = act ? active : !active;
    assign ready   = st_q.pend;
    assign running = st_q.running;

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
    import pwm_ctrl_pkg::*;
#(
    parameter int          NCH      = 2,
    parameter int          AW       = 8,
    parameter int unsigned DIV_UNIT = 60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_o
);

    chan_cfg_t [NCH-1:0]  cfg_w;
    logic [NCH-1:0][31:0] pd_w;
    logic [NCH-1:0]       pd_wr_w;
    logic [NCH-1:0]       rdy_w;
    logic [NCH-1:0]       run_w;
    logic [NCH-1:0]       wrap_w;
    logic [NCH-1:0]       tick_w;
    logic [NCH-1:0]       wave_w;
    logic [NCH-1:0]       byp_w;
    logic [NCH-1:0]       act_w;

    pwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ready (rdy_w),
        .rdata (bus_rdata),
        .cfg   (cfg_w),
        .pd    (pd_w),
        .pd_wr (pd_wr_w)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign byp_w[g] = cfg_w[g].byp;
        assign act_w[g] = cfg_w[g].act;

        pwm_prescaler #(.DIV_UNIT(DIV_UNIT)) u_psc (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_w[g]),
            .code  (cfg_w[g].psc),
            .tick  (tick_w[g])
        );

        pwm_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_w[g]),
            .req     (cfg_w[g].gate && cfg_w[g].en),
            .byp     (cfg_w[g].byp),
            .act     (cfg_w[g].act),
            .pd_wr   (pd_wr_w[g]),
            .pd      (pd_w[g]),
            .wave    (wave_w[g]),
            .ready   (rdy_w[g]),
            .running (run_w[g]),
            .wrap    (wrap_w[g])
        );

        assign pwm_o[g] = cfg_w[g].byp ? clk : wave_w[g];
    end

endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk #(
    parameter int NCH = 2,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           we,
    input logic [AW-1:0]  addr,
    input logic [NCH-1:0] byp,
    input logic [NCH-1:0] act,
    input logic [NCH-1:0] run,
    input logic [NCH-1:0] wrap,
    input logic [NCH-1:0] rdy,
    input logic [NCH-1:0] pin
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7
        ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == AW'(4 * (g + 1))) |=> rdy[g]);

        // R6
        load_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rdy[g]) |-> ($past(!run[g]) || $past(wrap[g])));

        // R8
        stop_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(run[g]) && !$past(byp[g])) |-> $past(wrap[g]));

        // R2
        idle_rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!byp[g] && !run[g]) |-> (pin[g] == !act[g]));

        // R9
        bypass_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
            byp[g] |=> !run[g]);
    end

endmodule

bind pwm_dual_ctrl pwm_dual_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bus_we),
    .addr (bus_addr),
    .byp  (byp_w),
    .act  (act_w),
    .run  (run_w),
    .wrap (wrap_w),
    .rdy  (rdy_w),
    .pin  (pwm_o)
);

// File: tb/pwm_dual_ctrl_bench.sv
module pwm_dual_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 2;
    localparam int AW    = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    ch;
        logic  val;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    pwm_dual_ctrl #(.NCH(NCH), .AW(AW), .DIV_UNIT(1)) u_pwm_dual_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
        end
    endtask

    function automatic logic wave_bit(int k, int d, int prd, int duty, bit act);
        int cnt;
        cnt = (k / d) % (prd + 1);
        return act ? (cnt < duty) : !(cnt < duty);
    endfunction

    task automatic push(input int ch, input logic v, input string tag);
        item_t it;
        it.ch = ch; it.val = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic stream(input int ch, input int n, input int d, input int prd,
                          input int duty, input bit act, input string tag);
        for (int k = 0; k < n; k++) begin
            push(ch, wave_bit(k, d, prd, duty, act), tag);
        end
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp_v, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp_v, tag, bus_rdata, exp_v);
        bus_addr = '0;
    endtask

    // Scoreboard monitor: one sample per cycle, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(pwm_o[it.ch] === it.val, it.tag, 32'(pwm_o[it.ch]), 32'(it.val));
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset values
        check(pwm_o == 2'b11, "R10 pins after reset", 32'(pwm_o), 32'h3);
        rd_chk(8'h00, 32'h0, "R10 control after reset");
        rd_chk(8'h04, 32'h0, "R10 period word after reset");

        // R1 / R7 / R6: period word write, ready flag, idle load
        bus_wr(8'h04, {16'd3, 16'd2});
        rd_chk(8'h00, 32'h1000_0000, "R7 ready set after write");
        @(negedge clk);
        rd_chk(8'h00, 32'h0, "R6 idle channel loads next cycle");
        rd_chk(8'h04, {16'd3, 16'd2}, "R1 period word readback");
        bus_wr(8'h08, 32'h0002_0001);
        @(negedge clk);
        rd_chk(8'h08, 32'h0002_0001, "R1 second period word readback");
        rd_chk(8'h0C, 32'h0, "R1 unmapped address reads zero");
        bus_wr(8'h00, 32'h3000_7D80);
        rd_chk(8'h00, 32'h0000_0180, "R1 mode/pulse kept, reserved and ready dropped");
        bus_wr(8'h00, 32'h0);

        // R3 / R4 / R5: divide-by-one, active high, P=3 D=2
        bus_wr(8'h00, 32'h0000_007F);
        stream(0, 12, 1, 3, 2, 1'b1, "R3 direct clock waveform");
        drain();

        // R8: clear enable mid-period, period completes
        bus_wr(8'h00, 32'h0000_006F);
        push(0, 1'b1, "R8 still running after disable");
        push(0, 1'b0, "R8 tail of period");
        push(0, 1'b0, "R8 tail of period");
        push(0, 1'b0, "R8 stopped at wrap");
        push(0, 1'b0, "R8 stays at rest");
        drain();

        // R6 / R7: update while running waits for the wrap
        bus_wr(8'h00, 32'h0000_007F);
        stream(0, 6, 1, 3, 2, 1'b1, "R5 active-high restart");
        drain();
        bus_wr(8'h04, {16'd1, 16'd1});
        rd_chk(8'h00, 32'h1000_007F, "R7 ready while value pending");
        push(0, 1'b0, "R6 old value until wrap");
        push(0, 1'b1, "R6 new value after wrap");
        push(0, 1'b0, "R6 new value");
        push(0, 1'b1, "R6 new value");
        push(0, 1'b0, "R6 new value");
        drain();
        rd_chk(8'h00, 32'h0000_007F, "R7 ready cleared after load");

        // R2: gate alone, then enable alone, inverted level
        bus_wr(8'h00, 32'h0000_004F);
        for (int i = 0; i < 6; i++) push(0, 1'b1, "R2 gate without enable rests");
        drain();
        bus_wr(8'h00, 32'h0000_001F);
        for (int i = 0; i < 6; i++) push(0, 1'b1, "R2 enable without gate rests");
        drain();

        // R3: duty of zero
        bus_wr(8'h04, {16'd3, 16'd0});
        bus_wr(8'h00, 32'h0000_007F);
        for (int i = 0; i < 8; i++) push(0, 1'b0, "R3 zero duty stays inactive");
        drain();

        // R4 / R5: channel 1, code 1 divides by 3, inverted
        bus_wr(8'h08, {16'd2, 16'd1});
        bus_wr(8'h00, 32'h0028_8000);
        stream(1, 18, 3, 2, 1, 1'b0, "R4 divide-by-three inverted (R5)");
        drain();

        // R4: frozen code holds the counter
        bus_wr(8'h00, 32'h0);
        repeat (12) @(negedge clk);
        bus_wr(8'h00, 32'h002D_0000);
        for (int i = 0; i < 10; i++) push(1, 1'b0, "R4 frozen divider code");
        drain();

        // R9: bypass drives the module clock
        bus_wr(8'h00, 32'h012D_0000);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #(CLK_P/4);
            check(pwm_o[1] === 1'b1, "R9 bypass high phase", 32'(pwm_o[1]), 32'h1);
            @(negedge clk); #(CLK_P/4);
            check(pwm_o[1] === 1'b0, "R9 bypass low phase", 32'(pwm_o[1]), 32'h0);
            check(pwm_o[0] === 1'b1, "R9 other channel untouched", 32'(pwm_o[0]), 32'h1);
        end
        bus_wr(8'h00, 32'h0100_0000);
        @(posedge clk); #(CLK_P/4);
        check(pwm_o[1] === 1'b1, "R9 bypass without enable high", 32'(pwm_o[1]), 32'h1);
        @(negedge clk); #(CLK_P/4);
        check(pwm_o[1] === 1'b0, "R9 bypass without enable low", 32'(pwm_o[1]), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule